// File: doc/BRIEF.md
# Latch-Reload Cycle Interrupt Timer

This block is a programmable interrupt timer that sits on an 8-bit CPU bus. The CPU fills a 16-bit reload latch four bits at a time through four write-only register windows. A control window arms the timer and picks its mode, and an acknowledge window releases the interrupt. Writes arrive as an already-qualified strobe. Only address bits 15:12 select the window, and the strobe's lower address bits are never seen here.

Once armed, the counter advances by one on every cycle in which the CPU clock-enable is high. In full mode it counts all 16 bits. In byte mode it counts only the low eight bits and leaves the upper eight alone. When the counted part wraps past all-ones, the timer sets a pending flag and reloads the counted part from the latch. The pending flag drives a level interrupt. Software clears it through the control or acknowledge window, and an acknowledge can re-arm or stop the timer in the same write.

Top module: `cyc_irq_timer`

## Requirements
- R1: A write with region code 0x8, 0x9, 0xA or 0xB stores `wr_data_i[3:0]` into latch bits 3:0, 7:4, 11:8 or 15:12 respectively. `wr_data_i[7:4]` is discarded.
- R2: A write with region code 0xC sets the ack-rearm bit from data bit 0, the run bit from data bit 1 and byte mode from data bit 2, and clears the pending flag.
- R3: A region 0xC write with data bit 1 set copies all 16 latch bits into the counter in that same clock edge.
- R4: A write with region code 0xD clears the pending flag and copies the ack-rearm bit into the run bit. The written data has no effect, and the counter is not reloaded.
- R5: While the run bit is clear, the counter keeps its value and the pending flag is never set.
- R6: In full mode, each counting cycle adds one to the counter. On the step from 0xFFFF it sets pending and reloads all 16 bits from the latch, so latch 0xFFFD raises the interrupt after the third counting cycle.
- R7: In byte mode, only counter bits 7:0 advance and bits 15:8 never change. On the step from 0xFF in the low byte, pending is set and only the low byte is reloaded from latch bits 7:0.
- R8: `irq_o` is an active-high level equal to the pending flag. It stays high until a region 0xC or 0xD write, whatever further wraps or other writes occur.
- R9: A counting cycle needs `cpu_ce_i` high. Any write strobe in a cycle takes priority and suppresses that cycle's count.
- R10: After reset the counter, latch, control bits and pending flag are zero and `irq_o` is low.
- R11: Writes with a region code outside 0x8 to 0xD change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Qualified CPU write strobe, one cycle |
| wr_region_i | input | 4 | CPU address bits 15:12 of the write |
| wr_data_i | input | 8 | CPU write data |
| cpu_ce_i | input | 1 | One-cycle CPU clock-enable, the counting tick |
| irq_o | output | 1 | Level interrupt, high while pending |

## Verification
Every register write and every counting tick takes effect on the clock edge where it is sampled, and `irq_o` comes straight from the pending register. The result of a stimulus driven before edge N is therefore due on `irq_o` right after edge N. The driver applies each stimulus just after a falling edge and queues the expected `irq_o` for the next rising edge. The monitor compares that value at the following falling edge, which keeps exactly one cycle between stimulus and check. Long intervals, such as the 259 ticks after leaving byte mode, are checked every single cycle, so an early interrupt is caught on the exact edge where it appears.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
  localparam int unsigned REGION_W = 4;
  localparam logic [REGION_W-1:0] LATCH_BASE = 4'h8;
  localparam logic [REGION_W-1:0] CTRL_CODE  = 4'hC;
  localparam logic [REGION_W-1:0] ACK_CODE   = 4'hD;

  // Control data bit positions
  localparam int unsigned CTRL_REARM_BIT = 0;
  localparam int unsigned CTRL_RUN_BIT   = 1;
  localparam int unsigned CTRL_MODE8_BIT = 2;

  typedef struct packed {
    logic rearm;
    logic run;
    logic mode8;
  } ctrl_t;
endpackage

// File: rtl/cyc_timer_regs.sv
module cyc_timer_regs
  import cyc_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [REGION_W-1:0] wr_region_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [CNT_W-1:0]    latch_o,
  output ctrl_t               ctrl_o,
  output logic                ctrl_wr_o,
  output logic                ack_wr_o
);
  localparam int unsigned NIBS = CNT_W / NIB_W;

  assign ctrl_wr_o = wr_en_i && (wr_region_i == CTRL_CODE);
  assign ack_wr_o  = wr_en_i && (wr_region_i == ACK_CODE);

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    localparam logic [REGION_W-1:0] CODE = LATCH_BASE + REGION_W'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) latch_o[g*NIB_W +: NIB_W] <= '0;
      else if (wr_en_i && wr_region_i == CODE)
        latch_o[g*NIB_W +: NIB_W] <= wr_data_i[NIB_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
    end else if (ctrl_wr_o) begin
      ctrl_o.rearm <= wr_data_i[CTRL_REARM_BIT];
      ctrl_o.run   <= wr_data_i[CTRL_RUN_BIT];
      ctrl_o.mode8 <= wr_data_i[CTRL_MODE8_BIT];
    end else if (ack_wr_o) begin
      ctrl_o.run <= ctrl_o.rearm;
    end
  end

  // R4
  ack_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_wr_o |=> ctrl_o.run == $past(ctrl_o.rearm));
  // R1
  latch_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(latch_o));
endmodule

// File: rtl/cyc_timer_count.sv
module cyc_timer_count #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned LOW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             mode8_i,
  input  logic [CNT_W-1:0] latch_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic lo_full, all_full;

  assign lo_full  = &cnt_o[LOW_W-1:0];
  assign all_full = &cnt_o;
  assign wrap_o   = tick_i && !load_i && (mode8_i ? lo_full : all_full);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (load_i) begin
      cnt_o <= latch_i;
    end else if (tick_i) begin
      if (mode8_i) begin
        if (lo_full) cnt_o[LOW_W-1:0] <= latch_i[LOW_W-1:0];
        else         cnt_o[LOW_W-1:0] <= cnt_o[LOW_W-1:0] + LOW_W'(1);
      end else begin
        if (all_full) cnt_o <= latch_i;
        else          cnt_o <= cnt_o + CNT_W'(1);
      end
    end
  end

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !load_i |=> $stable(cnt_o));
  // R7
  hi_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && mode8_i && !load_i |=> $stable(cnt_o[CNT_W-1:LOW_W]));
  // R3
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == $past(latch_i));
endmodule

// File: rtl/cyc_timer_pend.sv
module cyc_timer_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_o <= 1'b0;
    else if (clr_i) pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
  end

  // R2
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pend_o);
  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && !clr_i |=> pend_o);
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cyc_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned LOW_W  = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [REGION_W-1:0] wr_region_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                cpu_ce_i,
  output logic                irq_o
);
  logic [CNT_W-1:0] latch, cnt;
  ctrl_t            ctrl;
  logic             ctrl_wr, ack_wr, tick, load, wrap;

  cyc_timer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .NIB_W(NIB_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_region_i, .wr_data_i,
    .latch_o(latch), .ctrl_o(ctrl), .ctrl_wr_o(ctrl_wr), .ack_wr_o(ack_wr)
  );

  // Any write owns the cycle; the tick is dropped
  assign tick = cpu_ce_i && ctrl.run && !wr_en_i;
  assign load = ctrl_wr && wr_data_i[CTRL_RUN_BIT];

  cyc_timer_count #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(load), .mode8_i(ctrl.mode8),
    .latch_i(latch), .cnt_o(cnt), .wrap_o(wrap)
  );

  cyc_timer_pend u_pend (
    .clk_i, .rst_ni, .set_i(wrap), .clr_i(ctrl_wr || ack_wr), .pend_o(irq_o)
  );

  // R5
  rise_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(cpu_ce_i && !wr_en_i && ctrl.run));
  // R9
  wr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !load |=> $stable(cnt));
  // R11
  other_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_region_i < LATCH_BASE || wr_region_i > ACK_CODE)
      |=> $stable(irq_o) && $stable(latch) && $stable(ctrl));
endmodule

// File: tb/tb_cyc_irq_timer.sv
`timescale 1ns/1ps
module tb_cyc_irq_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_region_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       cpu_ce_i = 1'b0;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit    exp_q[$];
  string tag_q[$];
  bit    exp_v;
  string tag_v;

  always #4 clk_i = ~clk_i;

  cyc_irq_timer dut (.*);

  // Monitor: result of stimulus is due after one rising edge
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      exp_v = exp_q.pop_front();
      tag_v = tag_q.pop_front();
      n_chk++;
      if (irq_o !== exp_v) begin
        n_fail++;
        $display("FAIL %s: irq_o=%b expected=%b at %0t", tag_v, irq_o, exp_v, $time);
      end
    end
  end

  task automatic cyc(input logic we, input logic [3:0] rg, input logic [7:0] d,
                     input logic ce, input bit exp, input string tag);
    @(negedge clk_i);
    #1;
    wr_en_i = we; wr_region_i = rg; wr_data_i = d; cpu_ce_i = ce;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [3:0] rg, input logic [7:0] d, input bit exp, input string tag);
    cyc(1'b1, rg, d, 1'b0, exp, tag);
  endtask

  task automatic tk(input bit exp, input string tag);
    cyc(1'b0, 4'h0, 8'h00, 1'b1, exp, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (irq_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: irq_o=%b expected=0 in reset", irq_o);
    end
    rst_ni = 1'b1;

    // R10: idle after reset, nothing armed
    for (int i = 0; i < 5; i++) tk(1'b0, "R10 idle after reset");

    // R1 latch 0xFFFD with junk in upper data bits; R3 arm loads counter
    wr(4'h8, 8'h7D, 1'b0, "R1 nib0");
    wr(4'h9, 8'hFF, 1'b0, "R1 nib1");
    wr(4'hA, 8'h0F, 1'b0, "R1 nib2");
    wr(4'hB, 8'hEF, 1'b0, "R1 nib3");
    wr(4'hC, 8'h02, 1'b0, "R3 arm full mode");
    tk(1'b0, "R6 tick1");
    tk(1'b0, "R6 tick2");
    tk(1'b1, "R6 tick3 wrap");
    tk(1'b1, "R8 sticky after wrap");
    cyc(1'b0, 4'h0, 8'h00, 1'b0, 1'b1, "R8 no ce");
    wr(4'hE, 8'hFF, 1'b1, "R11 region E ignored");
    wr(4'h0, 8'hFF, 1'b1, "R11 region 0 ignored");
    wr(4'hC, 8'h00, 1'b0, "R2 control clears pending");
    for (int i = 0; i < 10; i++) tk(1'b0, "R5 stopped counter");

    // R4 ack with rearm=0 stops timer
    wr(4'hC, 8'h02, 1'b0, "R3 rearm load");
    tk(1'b0, "R6 tick1");
    tk(1'b0, "R6 tick2");
    tk(1'b1, "R6 tick3 wrap");
    wr(4'hD, 8'hFF, 1'b0, "R4 ack clears");
    for (int i = 0; i < 10; i++) tk(1'b0, "R4 ack stopped run");

    // R4 ack with rearm=1 keeps running; R6 full reload
    wr(4'hC, 8'h03, 1'b0, "R2 arm with rearm");
    tk(1'b0, "R6 tick1");
    tk(1'b0, "R6 tick2");
    tk(1'b1, "R6 tick3 wrap");
    wr(4'hD, 8'h00, 1'b0, "R4 ack rearms");
    tk(1'b0, "R6 reload tick1");
    tk(1'b0, "R6 reload tick2");
    tk(1'b1, "R6 reload tick3 wrap");

    // R9 write beats tick; ce low does not count
    wr(4'hD, 8'h00, 1'b0, "R4 ack");
    tk(1'b0, "R9 tick1");
    cyc(1'b1, 4'h8, 8'h0D, 1'b1, 1'b0, "R9 write with ce");
    cyc(1'b0, 4'h0, 8'h00, 1'b0, 1'b0, "R9 ce low");
    tk(1'b0, "R9 tick2");
    tk(1'b1, "R9 tick3 wrap");

    // R7 byte mode, latch 0xFEFD
    wr(4'h8, 8'hAD, 1'b1, "R8 latch write keeps pending");
    wr(4'h9, 8'h5F, 1'b1, "R8 latch write keeps pending");
    wr(4'hA, 8'hCE, 1'b1, "R8 latch write keeps pending");
    wr(4'hB, 8'h3F, 1'b1, "R8 latch write keeps pending");
    wr(4'hC, 8'h06, 1'b0, "R7 arm byte mode");
    tk(1'b0, "R7 tick1");
    tk(1'b0, "R7 tick2");
    tk(1'b1, "R7 low byte wrap");
    // stop without reload, switch to full mode, restart via ack
    wr(4'hC, 8'h01, 1'b0, "R2 stop, full mode");
    wr(4'hD, 8'h00, 1'b0, "R4 restart no reload");
    // counter must still be 0xFEFD: 259 ticks to wrap
    for (int i = 0; i < 258; i++) tk(1'b0, "R7 high byte unchanged");
    tk(1'b1, "R7 full wrap after 259");

    cyc(1'b0, 4'h0, 8'h00, 1'b0, 1'b1, "R8 hold");
    repeat (3) @(negedge clk_i);
    summary();
    $finish;
  end
endmodule